// File: doc/BRIEF.md
# Serial Control and Status Port

This block gives a microcontroller a byte-wide, full-duplex serial path into a line device. The port runs from its own serial clock, independent of the data interfaces. While the chip-select is held low, the port shifts in one control byte and shifts out one status byte at the same time. The port keeps the received control byte in a register and drives that register to the rest of the chip. The status byte is built from three inputs: a line-signal detect flag, a loop-sync flag and a one-cycle bipolar-violation pulse.

The serial pins are sampled through synchronizers on the system clock, and the port acts on edges detected there. An active-low interrupt line tells the microcontroller that one of the two flags has changed. The violation bit is a sticky counter substitute: software polls it once per access and sees whether any violation arrived since the last access.

Every access rewrites the control register. A read that must leave the mode unchanged therefore has to resend the current control byte.

Top module: `sctl_port`

## Requirements
- R1: A full access is eight rising serial-clock edges with chip-select low. Data is sampled on each rising edge, most significant bit first. The eighth rising edge loads the received byte into the control output.
- R2: The status byte is shifted out most significant bit first. Its first bit is on the data output once chip-select has fallen, and each later bit follows a falling serial-clock edge. Bit 0 is signal detect, bit 1 is loop sync, bit 2 is the violation flag, and bits 7..3 read 0. The data output reads 0 while chip-select is high.
- R3: A change of the signal-detect or loop-sync input, in either direction, drives the interrupt output low. The interrupt then stays low until it is cleared as in R4.
- R4: The interrupt clears on the first rising serial-clock edge of an access. If a flag change falls in the same cycle as that clear, the interrupt stays low.
- R5: A violation pulse sets the sticky violation bit and never drives the interrupt low.
- R6: Each falling edge of chip-select clears the violation bit. A violation that arrives in the same cycle as that fall, or at any time during an access, is reported at the next access.
- R7: An access ended by chip-select rising before the eighth rising edge leaves the control output unchanged. Rising edges after the eighth one in the same access are ignored.
- R8: The status byte is captured when chip-select falls. Flag changes during the shift appear only at the next access.
- R9: After reset the control output is 0x00, the interrupt output is high and the data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock from the microcontroller, idles low |
| ser_cs_n | input | 1 | Active-low chip-select framing one access |
| ser_din | input | 1 | Serial control data in |
| ser_dout | output | 1 | Serial status data out |
| sig_det | input | 1 | Line-signal detect flag (clk domain) |
| loop_sync | input | 1 | Loop-sync flag (clk domain) |
| bpv_pulse | input | 1 | One-cycle pulse per coding violation (clk domain) |
| ctrl_out | output | 8 | Current control register |
| irq_n | output | 1 | Active-low latched interrupt |

## Verification
Two pairs of functions can fall in the same system-clock cycle:

- **Interrupt set and clear.** A loop-sync change can coincide with the first detected rising serial edge. The bench drives the flag toggle exactly the synchronizer delay after the serial clock rises, so both events are registered together. The bench expects the interrupt to remain low after the access.
- **Violation set and clear.** A violation pulse can coincide with the chip-select fall that clears the sticky bit. The bench expects that access to report no violation and the next access to report it.

Aborted and over-long accesses, and flag changes during the shift, are judged by the control output and by the status byte of the following access.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    localparam int BYTE_W  = 8;
    localparam int ST_SD   = 0;
    localparam int ST_LS   = 1;
    localparam int ST_VIOL = 2;
    localparam int SYNC_N  = 2;
    typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_d, chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = d;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], d};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/sctl_shift.sv
module sctl_shift #(
    parameter int W = sctl_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_s,
    input  logic         sclk_s,
    input  logic         din_s,
    input  logic [W-1:0] status_in,
    output logic [W-1:0] ctrl_out,
    output logic         dout,
    output logic         cs_fall,
    output logic         first_rise
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] DONE = CNT_W'(W);

    typedef struct packed {
        logic             cs_prev;
        logic             sclk_prev;
        logic [CNT_W-1:0] cnt;
        logic [W-2:0]     rx;
        logic [W-1:0]     tx;
        logic [W-1:0]     ctrl;
    } shift_st_t;

    shift_st_t st_d, st_q;
    logic rise, fall;

    always_comb begin
        cs_fall    = st_q.cs_prev & ~cs_s;
        rise       = ~st_q.sclk_prev & sclk_s & ~cs_s;
        fall       = st_q.sclk_prev & ~sclk_s & ~cs_s;
        first_rise = rise & ~cs_fall & (st_q.cnt == '0);

        st_d           = st_q;
        st_d.cs_prev   = cs_s;
        st_d.sclk_prev = sclk_s;
        if (cs_fall) begin
            st_d.tx  = status_in;
            st_d.cnt = '0;
        end else if (rise && st_q.cnt != DONE) begin
            st_d.rx  = {st_q.rx[W-3:0], din_s};
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == LAST) st_d.ctrl = {st_q.rx, din_s};
        end else if (fall && st_q.cnt != '0) begin
            st_d.tx = {st_q.tx[W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q           <= '0;
            st_q.cs_prev   <= 1'b1;
            st_q.cnt       <= DONE;
        end else begin
            st_q <= st_d;
        end
    end

    assign ctrl_out = st_q.ctrl;
    assign dout     = ~cs_s & st_q.tx[W-1];

    AST_CTRL_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> $stable(ctrl_out)); // R7
    AST_SNAP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_s && !cs_fall && !fall) |=> $stable(st_q.tx)); // R8
    AST_DOUT_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |-> !dout); // R2
endmodule

// File: rtl/sctl_status.sv
module sctl_status #(
    parameter int W = sctl_pkg::BYTE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sig_det,
    input  logic         loop_sync,
    input  logic         bpv_pulse,
    input  logic         cs_fall,
    input  logic         first_rise,
    output logic [W-1:0] status,
    output logic         irq_n
);
    typedef struct packed {
        logic sd;
        logic ls;
        logic viol;
        logic irq;
    } stat_st_t;

    stat_st_t st_d, st_q;
    logic flag_chg;

    always_comb begin
        flag_chg = (sig_det ^ st_q.sd) | (loop_sync ^ st_q.ls);
        st_d     = st_q;
        st_d.sd  = sig_det;
        st_d.ls  = loop_sync;
        if (flag_chg)        st_d.irq = 1'b1;
        else if (first_rise) st_d.irq = 1'b0;
        if (bpv_pulse)       st_d.viol = 1'b1;
        else if (cs_fall)    st_d.viol = 1'b0;

        status                   = '0;
        status[sctl_pkg::ST_SD]   = st_q.sd;
        status[sctl_pkg::ST_LS]   = st_q.ls;
        status[sctl_pkg::ST_VIOL] = st_q.viol;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_n = ~st_q.irq;

    AST_IRQ_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (sig_det != st_q.sd || loop_sync != st_q.ls) |=> !irq_n); // R3
    AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (first_rise && sig_det == st_q.sd && loop_sync == st_q.ls) |=> irq_n); // R4
    AST_VIOL_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n && sig_det == st_q.sd && loop_sync == st_q.ls) |=> irq_n); // R5
    AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        bpv_pulse |=> status[sctl_pkg::ST_VIOL]); // R6
endmodule

// File: rtl/sctl_port.sv
module sctl_port #(
    parameter int W     = sctl_pkg::BYTE_W,
    parameter int SYNCS = sctl_pkg::SYNC_N
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_clk,
    input  logic         ser_cs_n,
    input  logic         ser_din,
    output logic         ser_dout,
    input  logic         sig_det,
    input  logic         loop_sync,
    input  logic         bpv_pulse,
    output logic [W-1:0] ctrl_out,
    output logic         irq_n
);
    localparam int          NPIN    = 3;
    localparam logic [NPIN-1:0] PIN_RST = 3'b100;

    logic [NPIN-1:0] pin_raw, pin_s;
    logic [W-1:0]    status;
    logic            cs_fall, first_rise;

    assign pin_raw = {ser_cs_n, ser_clk, ser_din};

    generate
        for (genvar g = 0; g < NPIN; g++) begin : g_sync
            sctl_sync #(.STAGES(SYNCS), .RST_VAL(PIN_RST[g])) u_sync (
                .clk(clk), .rst_n(rst_n), .d(pin_raw[g]), .q(pin_s[g]));
        end
    endgenerate

    sctl_shift #(.W(W)) u_shift (
        .clk(clk), .rst_n(rst_n),
        .cs_s(pin_s[2]), .sclk_s(pin_s[1]), .din_s(pin_s[0]),
        .status_in(status), .ctrl_out(ctrl_out), .dout(ser_dout),
        .cs_fall(cs_fall), .first_rise(first_rise));

    sctl_status #(.W(W)) u_status (
        .clk(clk), .rst_n(rst_n),
        .sig_det(sig_det), .loop_sync(loop_sync), .bpv_pulse(bpv_pulse),
        .cs_fall(cs_fall), .first_rise(first_rise),
        .status(status), .irq_n(irq_n));

    AST_CTRL_HOLD_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(ctrl_out) |-> !pin_s[2]); // R1
endmodule

// File: tb/tb_sctl_port.sv
module tb_sctl_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_cs_n = 1'b1, ser_din = 1'b0;
    logic sig_det = 1'b0, loop_sync = 1'b0, bpv_pulse = 1'b0;
    logic ser_dout, irq_n;
    logic [7:0] ctrl_out;

    int tests = 0, fails = 0;
    bit done = 1'b0;
    logic [7:0] exp_q[$], act_q[$];
    string      tag_q[$];

    always #10 clk = ~clk;

    sctl_port dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_cs_n(ser_cs_n),
        .ser_din(ser_din), .ser_dout(ser_dout), .sig_det(sig_det),
        .loop_sync(loop_sync), .bpv_pulse(bpv_pulse),
        .ctrl_out(ctrl_out), .irq_n(irq_n));

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // hook: 0 none, 1 loop_sync toggle on first rise, 2 violation on cs fall,
    // 3 violation mid transfer, 4 sig_det toggle mid transfer
    task automatic xfer(input logic [7:0] cbyte, input int nbits, input int hook,
                        input logic [7:0] exp_st, input string tag);
        logic [15:0] sh;
        logic [7:0]  rx;
        sh = {cbyte, 8'hFF};
        rx = '0;
        if (nbits >= 8) begin
            exp_q.push_back(exp_st);
            tag_q.push_back(tag);
        end
        @(negedge clk);
        ser_cs_n = 1'b0;
        if (hook == 2) begin
            wait_n(2);
            bpv_pulse = 1'b1;
            wait_n(1);
            bpv_pulse = 1'b0;
            wait_n(5);
        end else begin
            wait_n(8);
        end
        for (int i = 0; i < nbits; i++) begin
            ser_din = sh[15];
            sh = sh << 1;
            wait_n(4);
            if (i < 8) rx[7-i] = ser_dout;
            ser_clk = 1'b1;
            if (i == 0 && hook == 1) begin
                wait_n(2);
                loop_sync = ~loop_sync;
                wait_n(6);
            end else if (i == 3 && hook == 3) begin
                wait_n(3);
                bpv_pulse = 1'b1;
                wait_n(1);
                bpv_pulse = 1'b0;
                wait_n(4);
            end else if (i == 3 && hook == 4) begin
                wait_n(3);
                sig_det = ~sig_det;
                wait_n(5);
            end else begin
                wait_n(8);
            end
            ser_clk = 1'b0;
            wait_n(8);
        end
        ser_cs_n = 1'b1;
        wait_n(8);
        if (nbits >= 8) act_q.push_back(rx);
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0 && exp_q.size() > 0) begin
                logic [7:0] a, e;
                string t;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(a == e, t, a, e);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog actual=00 expected=01");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_n(5);
        rst_n = 1'b1;
        wait_n(3);
        chk(irq_n == 1'b1, "R9 irq_n", {7'b0, irq_n}, 8'h01);
        chk(ctrl_out == 8'h00, "R9 ctrl", ctrl_out, 8'h00);
        chk(ser_dout == 1'b0, "R9 dout", {7'b0, ser_dout}, 8'h00);

        sig_det = 1'b1;
        wait_n(3);
        chk(irq_n == 1'b0, "R3 sig_det rise", {7'b0, irq_n}, 8'h00);
        xfer(8'hA5, 8, 0, 8'h01, "R2 status sd");
        chk(ctrl_out == 8'hA5, "R1 ctrl load", ctrl_out, 8'hA5);
        chk(irq_n == 1'b1, "R4 irq clear", {7'b0, irq_n}, 8'h01);

        bpv_pulse = 1'b1;
        wait_n(1);
        bpv_pulse = 1'b0;
        wait_n(3);
        chk(irq_n == 1'b1, "R5 no irq on violation", {7'b0, irq_n}, 8'h01);
        xfer(8'hA5, 8, 0, 8'h05, "R5 sticky violation");
        xfer(8'h3C, 8, 0, 8'h01, "R6 violation cleared");
        chk(ctrl_out == 8'h3C, "R1 ctrl rewrite", ctrl_out, 8'h3C);

        xfer(8'hC3, 4, 0, 8'h00, "R7");
        chk(ctrl_out == 8'h3C, "R7 aborted keeps ctrl", ctrl_out, 8'h3C);
        xfer(8'h5A, 10, 0, 8'h01, "R7 long access status");
        chk(ctrl_out == 8'h5A, "R7 extra edges ignored", ctrl_out, 8'h5A);

        xfer(8'h5A, 8, 4, 8'h01, "R8 snapshot at cs fall");
        chk(irq_n == 1'b0, "R3 latched mid-access change", {7'b0, irq_n}, 8'h00);
        xfer(8'h5A, 8, 0, 8'h00, "R8 change seen next access");
        chk(irq_n == 1'b1, "R4 irq clear", {7'b0, irq_n}, 8'h01);

        xfer(8'h66, 8, 1, 8'h00, "R4 coincident access status");
        chk(irq_n == 1'b0, "R4 set wins over clear", {7'b0, irq_n}, 8'h00);
        xfer(8'h66, 8, 0, 8'h02, "R2 status ls");
        chk(irq_n == 1'b1, "R4 irq clear after", {7'b0, irq_n}, 8'h01);

        xfer(8'h81, 8, 2, 8'h02, "R6 violation at cs fall not shown");
        xfer(8'h81, 8, 0, 8'h06, "R6 violation at cs fall held");
        xfer(8'h81, 8, 3, 8'h02, "R6 violation mid access not shown");
        xfer(8'h81, 8, 0, 8'h06, "R6 violation mid access held");
        xfer(8'h81, 8, 0, 8'h02, "R6 cleared again");
        chk(ctrl_out == 8'h81, "R1 final ctrl", ctrl_out, 8'h81);
        chk(irq_n == 1'b1, "R5 irq still high", {7'b0, irq_n}, 8'h01);

        wait_n(10);
        if (exp_q.size() != 0) chk(1'b0, "R2 scoreboard drained", 8'(exp_q.size()), 8'h00);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule